// File: doc/BRIEF.md
# Alarm Change Interrupt Status Register

This block gathers receive-side alarm activity for one channel into a 4-bit sticky status register. It samples three alarm condition levels: loss of frame, alarm indication signal (AIS) and yellow alarm. Any change of a level, whether the alarm is declared or cleared, sets that level's status bit. A separate line code violation pulse input sets a fourth bit. The bits are never dropped by the hardware. They stay set until software clears them.

Software reaches the register over a simple register bus. The register's address combines a per-instance channel number in the upper nibble with a fixed offset in the lower nibble. A mode input selects how the bits are cleared. In one mode a read clears every bit it returns. In the other mode a write of ones clears the addressed bits. A per-bit enable vector picks which status bits may drive the single interrupt request. The request stays high while any enabled bit remains set.

Top module: `alarm_chg_irq`

## Requirements
- R1: After synchronous reset, every status bit, the read data and the interrupt output are 0.
- R2: Status bit positions: bit 3 line code violation, bit 2 loss of frame, bit 1 AIS, bit 0 yellow alarm. The register answers at address {CHAN_ID, REG_OFS}.
- R3: A rising alarm level sampled at clock edge k sets its status bit at edge k+1. A read sampled at edge k+2 returns the bit.
- R4: A falling alarm level sets its status bit with the same timing as R3.
- R5: A one-cycle high pulse on the violation input sets status bit 3.
- R6: A set status bit stays set for any length of time until a clear access reaches it.
- R7: With clr_on_rd=1, a register read returns the pre-clear status in bits 3:0 of bus_rdata one cycle later, with upper bits 0. The same edge clears all four status bits.
- R8: With clr_on_rd=0, writing 1 to a bit clears it and writing 0 leaves it unchanged. Reads do not clear any bit.
- R9: With clr_on_rd=1, register writes leave the status bits unchanged.
- R10: When an event and a clear for the same bit fall on the same edge, the bit ends up set.
- R11: irq is registered and equals the OR of (status AND irq_en) from the previous cycle. A bit with a 0 enable never raises irq.
- R12: An access to any other address returns 0 and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_on_rd | input | 1 | 1: reads clear; 0: write-one clears |
| alarm_lvl | input | 3 | Alarm levels: [2] loss of frame, [1] AIS, [0] yellow |
| lcv_pulse | input | 1 | Line code violation event pulse |
| irq_en | input | 4 | Per-bit interrupt enables |
| bus_addr | input | ADDR_W (8) | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with CHAN_ID=5, so the register sits at 0x52. Reads to 0x02 and to other channel nibbles must then miss, which the default channel 0 could not tell apart from a hit. The bus stays 8 bits wide, so the zero padding above the four status bits is checked on every read. A random phase switches the clear mode in mid-run and issues many accesses. This lets events and clears coincide on the same edge far more often than directed tests alone would.

// File: rtl/alarm_chg_pkg.sv
package alarm_chg_pkg;
  localparam int N_LVL  = 3;
  localparam int N_STAT = N_LVL + 1;
  localparam int BIT_LCV = 3;
  localparam int BIT_LOF = 2;
  localparam int BIT_AIS = 1;
  localparam int BIT_YEL = 0;
  typedef logic [N_STAT-1:0] stat_t;
endpackage

// File: rtl/chg_detect.sv
module chg_detect #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_in,
  input  logic         pulse_in,
  output logic [N:0]   evt
);
  logic [N-1:0] lvl_q, lvl_qq;
  logic         pulse_q;

  for (genvar i = 0; i < N; i++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (rst) begin
        lvl_q[i]  <= 1'b0;
        lvl_qq[i] <= 1'b0;
      end else begin
        lvl_q[i]  <= lvl_in[i];
        lvl_qq[i] <= lvl_q[i];
      end
    end
    assign evt[i] = lvl_q[i] ^ lvl_qq[i];
  end

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= pulse_in;
  end
  assign evt[N] = pulse_q;
endmodule

// File: rtl/sticky_status.sv
module sticky_status #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] status_q
);
  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= (status_q & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/alarm_chg_irq.sv
module alarm_chg_irq
  import alarm_chg_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int CHAN_W  = 4,
  parameter int CHAN_ID = 0,
  parameter int REG_OFS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_on_rd,
  input  logic [N_LVL-1:0]  alarm_lvl,
  input  logic              lcv_pulse,
  input  logic [N_STAT-1:0] irq_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int OFS_W = ADDR_W - CHAN_W;
  localparam logic [ADDR_W-1:0] HIT_ADDR =
    {CHAN_W'(CHAN_ID), OFS_W'(REG_OFS)};

  stat_t evt, status_q, clr_vec;
  logic  hit;

  chg_detect #(.N(N_LVL)) u_det (
    .clk(clk), .rst(rst), .lvl_in(alarm_lvl), .pulse_in(lcv_pulse), .evt(evt)
  );

  assign hit = (bus_addr == HIT_ADDR);

  always_comb begin
    clr_vec = '0;
    if (hit && bus_rd && clr_on_rd)       clr_vec = '1;
    else if (hit && bus_wr && !clr_on_rd) clr_vec = bus_wdata[N_STAT-1:0];
  end

  sticky_status #(.W(N_STAT)) u_stat (
    .clk(clk), .rst(rst), .set_vec(evt), .clr_vec(clr_vec), .status_q(status_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= (hit && bus_rd) ? DATA_W'(status_q) : '0;
      irq       <= |(status_q & irq_en);
    end
  end
endmodule

// File: rtl/alarm_chg_chk.sv
module alarm_chg_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int W = 4,
  parameter logic [ADDR_W-1:0] HIT_ADDR = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_on_rd,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [W-1:0]      irq_en,
  input logic [W-1:0]      status,
  input logic [W-1:0]      evt
);
  logic hit, clr_hit;
  assign hit = (bus_addr == HIT_ADDR);
  assign clr_hit = hit && ((clr_on_rd && bus_rd) || (!clr_on_rd && bus_wr));

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (status == '0 && irq == 1'b0 && bus_rdata == '0)); // R1

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(status & irq_en)))); // R11

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !clr_hit |=> ((status & $past(status)) == $past(status))); // R6

  AST_READ_PRECLEAR: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && hit) |=> (bus_rdata == DATA_W'($past(status)))); // R7

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & ~$past(status) & ~$past(evt)) == '0)); // R3

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & $past(evt)) == $past(evt))); // R10
endmodule

bind alarm_chg_irq alarm_chg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .W(alarm_chg_pkg::N_STAT), .HIT_ADDR(HIT_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .clr_on_rd(clr_on_rd), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq(irq), .irq_en(irq_en),
  .status(status_q), .evt(evt)
);

// File: tb/tb_alarm_chg_irq.sv
`timescale 1ns/1ps
module tb_alarm_chg_irq;
  localparam int CHAN = 5;
  localparam logic [7:0] HIT = 8'h52;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr_on_rd = 1'b1;
  logic [2:0] alarm_lvl = '0;
  logic       lcv_pulse = 1'b0;
  logic [3:0] irq_en = 4'hF;
  logic [7:0] bus_addr = HIT;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_run = 0, n_fail = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alarm_chg_irq #(.CHAN_ID(CHAN)) dut (
    .clk(clk), .rst(rst), .clr_on_rd(clr_on_rd), .alarm_lvl(alarm_lvl),
    .lcv_pulse(lcv_pulse), .irq_en(irq_en), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // Reference model from the requirements
  logic [2:0] m_l1, m_l2;
  logic       m_lcv, m_irq;
  logic [3:0] m_stat;
  logic [7:0] m_rdata;

  always @(posedge clk) begin
    logic [3:0] ev, clr;
    logic hit;
    if (rst) begin
      m_l1 = '0; m_l2 = '0; m_lcv = 1'b0; m_stat = '0; m_rdata = '0; m_irq = 1'b0;
    end else begin
      hit = (bus_addr == HIT);
      ev  = {m_lcv, m_l1 ^ m_l2};
      clr = '0;
      if (hit && bus_rd && clr_on_rd)       clr = 4'hF;
      else if (hit && bus_wr && !clr_on_rd) clr = bus_wdata[3:0];
      m_rdata = (hit && bus_rd) ? {4'h0, m_stat} : 8'h00;
      m_irq   = |(m_stat & irq_en);
      m_stat  = (m_stat & ~clr) | ev;
      m_l2 = m_l1; m_l1 = alarm_lvl; m_lcv = lcv_pulse;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      chk("R11 model irq", {7'h0, irq}, {7'h0, m_irq});
      chk("R7 model rdata", bus_rdata, m_rdata);
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    step();
    bus_rd = 1'b0; bus_addr = HIT;
    d = bus_rdata;
  endtask

  task automatic wr_reg(input logic [7:0] v);
    bus_addr = HIT; bus_wdata = v; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    step(3);
    rst = 1'b0;
    chk_on = 1'b1;
    step();
    chk("R1 irq after reset", {7'h0, irq}, 8'h0);
    rd_reg(HIT, d); chk("R1 status after reset", d, 8'h00);

    // R2 R3: rising loss of frame
    alarm_lvl[2] = 1'b1;
    step(2);
    chk("R11 irq not yet", {7'h0, irq}, 8'h0);
    step();
    chk("R11 irq raised", {7'h0, irq}, 8'h1);
    rd_reg(HIT, d); chk("R3 R2 lof rise bit2", d, 8'h04);
    rd_reg(HIT, d); chk("R7 cleared by read", d, 8'h00);
    chk("R11 irq dropped", {7'h0, irq}, 8'h0);

    alarm_lvl[2] = 1'b0; step(3);
    rd_reg(HIT, d); chk("R4 lof fall bit2", d, 8'h04);

    lcv_pulse = 1'b1; step(); lcv_pulse = 1'b0; step(2);
    rd_reg(HIT, d); chk("R5 lcv bit3", d, 8'h08);

    alarm_lvl[0] = 1'b1; step(3);
    rd_reg(8'h02, d); chk("R12 other channel reads 0", d, 8'h00);
    rd_reg(8'h53, d); chk("R12 other offset reads 0", d, 8'h00);
    rd_reg(HIT, d); chk("R12 no clear, R2 yel bit0", d, 8'h01);

    alarm_lvl[1] = 1'b1; step(3);
    wr_reg(8'hFF);
    rd_reg(HIT, d); chk("R9 write ignored, R2 ais bit1", d, 8'h02);

    clr_on_rd = 1'b0;
    alarm_lvl[1] = 1'b0; alarm_lvl[0] = 1'b0; step(3);
    rd_reg(HIT, d); chk("R8 read", d, 8'h03);
    rd_reg(HIT, d); chk("R8 read no clear", d, 8'h03);
    wr_reg(8'h01);
    rd_reg(HIT, d); chk("R8 write one clears only bit0", d, 8'h02);
    wr_reg(8'h02);
    rd_reg(HIT, d); chk("R8 all clear", d, 8'h00);

    alarm_lvl[2] = 1'b1; step(40);
    rd_reg(HIT, d); chk("R6 sticky after 40 cycles", d, 8'h04);
    wr_reg(8'h04);

    irq_en = 4'b1011;
    alarm_lvl[2] = 1'b0; step(4);
    chk("R11 masked bit no irq", {7'h0, irq}, 8'h0);
    irq_en = 4'hF; step(2);
    chk("R11 enable raises irq", {7'h0, irq}, 8'h1);
    wr_reg(8'h04); step();
    chk("R11 irq low after clear", {7'h0, irq}, 8'h0);

    clr_on_rd = 1'b1;
    alarm_lvl[1] = 1'b1; step();
    bus_rd = 1'b1; step(); bus_rd = 1'b0;
    chk("R10 read sees pre-event value", bus_rdata, 8'h00);
    rd_reg(HIT, d); chk("R10 event survives same-edge clear", d, 8'h02);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 15) == 0) alarm_lvl ^= 3'($urandom_range(1, 7));
      lcv_pulse = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 199) == 0) clr_on_rd = ~clr_on_rd;
      if ($urandom_range(0, 99) == 0) irq_en = 4'($urandom);
      bus_addr  = ($urandom_range(0, 4) == 0) ? 8'($urandom) : HIT;
      bus_rd    = ($urandom_range(0, 5) == 0);
      bus_wr    = ($urandom_range(0, 5) == 0);
      bus_wdata = 8'($urandom);
      step();
    end
    bus_rd = 1'b0; bus_wr = 1'b0;
    step(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule